// File: doc/BRIEF.md
# Burst-of-Two Dual-Port SRAM Core

This block is a synthesizable model of a quad-data-rate style static memory. It has a read port and a write port that work independently. Each port has its own active-low select, and the two ports share one address bus. The positive input clock and its complement are modelled by a single internal clock running at twice the rate. A phase register divides that clock into alternating slots. A "K slot" edge stands for a rising edge of the positive clock, and the "K# slot" edge that follows stands for a rising edge of the complementary clock.

Every access is a fixed burst of two words. One address selects a word pair, held in two banks: the first beat uses bank 0 and the second beat uses bank 1. Writes take data and per-lane byte masks on both slot edges and commit the whole pair at the K# edge. Reads capture their address on the K edge and present the two words on the two half-cycles that follow. A separate valid output stands in for the high-impedance output state. While valid is low, the data bus is held at zero.

Top module: `qdr_b2_sram`

## Requirements
- R1: After reset the first clock edge is a K edge. `k_phase_o` is high during every cycle whose closing edge is a K edge, and the slots alternate on every clock.
- R2: A write starts only when `wr_sel_ni` is low at a K edge. When `wr_sel_ni` is high at a K edge, the data, masks and address of that cycle pair leave the memory unchanged.
- R3: A read starts when `rd_sel_ni` is low at a K edge. From the next cycle `rvalid_o` is high for two cycles, with beat 0 first and then beat 1.
- R4: The read address is taken from `addr_i` at the K edge and the write address at the following K# edge. Select inputs are ignored at K# edges, and `addr_i` is ignored at any edge whose port is not selected.
- R5: Byte masks are active low, with one bit per 9-bit lane: `bw_ni[0]` covers data bits 8:0, `[1]` 17:9, `[2]` 26:18 and `[3]` 35:27. A lane whose mask bit is high keeps its old contents.
- R6: The write data and mask sampled at the K edge go to word 0 of the addressed pair, and those sampled at the K# edge go to word 1. A read returns word 0 as beat 0 and word 1 as beat 1.
- R7: If `rd_sel_ni` is high at a K edge, a second beat already under way still completes. After that K edge, `rvalid_o` is low and `rdata_o` is zero.
- R8: A read and a write to the same address started at the same K edge return the contents from before that write.
- R9: During reset and immediately after it, `rvalid_o` and `rdata_o` are zero and `k_phase_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Double-rate clock; edges alternate between K and K# slots |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_sel_ni | input | 1 | Read port select, active low, sampled at K edges |
| wr_sel_ni | input | 1 | Write port select, active low, sampled at K edges |
| addr_i | input | ADDR_W | Shared address: read address at K, write address at K# |
| wdata_i | input | LANE_W*LANES | Write data, one beat per slot edge |
| bw_ni | input | LANES | Per-lane byte write masks, active low, one beat per slot edge |
| rdata_o | output | LANE_W*LANES | Read burst data, zero when not valid |
| rvalid_o | output | 1 | High while read data is driven (stands in for the output enable) |
| k_phase_o | output | 1 | High when the next edge is a K edge |

## Verification
The bench fills every word pair and then runs the following cases: mixed masks, deselected writes with garbage data, reads and writes to the same address at the same K edge, and bursts that run back to back and then stop. It moves the address and selects to unrelated values on the slot where the port must ignore them.

Each of these cases catches a different fault:
- A design that swapped the banks or beats would return the two words of a pair in the wrong order.
- A design with a wrong lane slice would corrupt the neighbouring lanes.
- A design that sampled the selects or the address on the wrong phase would write to stray addresses.
- A write that bypassed into the read would give new data where old data is expected.
- An output enable that dropped too early would cut the second beat; one that dropped too late would leave stale data on the bus.

// File: rtl/qdr_b2_pkg.sv
package qdr_b2_pkg;
  localparam int unsigned BURST_LEN = 2;

  typedef enum logic {
    SLOT_K  = 1'b0,
    SLOT_KN = 1'b1
  } slot_e;
endpackage

// File: rtl/qdr_b2_phase.sv
module qdr_b2_phase
  import qdr_b2_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  output logic k_slot_o
);
  slot_e phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= SLOT_K;
    else         phase_q <= (phase_q == SLOT_K) ? SLOT_KN : SLOT_K;
  end

  assign k_slot_o = (phase_q == SLOT_K);
endmodule

// File: rtl/qdr_b2_bank.sv
module qdr_b2_bank #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         waddr_i,
  input  logic [LANE_W*LANES-1:0]   wdata_i,
  input  logic [LANES-1:0]          wlane_i,
  input  logic                      re_i,
  input  logic [ADDR_W-1:0]         raddr_i,
  output logic [LANE_W*LANES-1:0]   rdata_o
);
  localparam int unsigned DATA_W = LANE_W * LANES;
  localparam int unsigned DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      for (int l = 0; l < LANES; l++) begin
        if (wlane_i[l]) mem_q[waddr_i][l*LANE_W +: LANE_W] <= wdata_i[l*LANE_W +: LANE_W];
      end
    end
  end

  // read and write share no edge, so no bypass is needed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= mem_q[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/qdr_b2_wr_path.sv
module qdr_b2_wr_path #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 4
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              k_slot_i,
  input  logic                              wr_sel_ni,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [LANE_W*LANES-1:0]           wdata_i,
  input  logic [LANES-1:0]                  bw_ni,
  output logic                              we_o,
  output logic [ADDR_W-1:0]                 waddr_o,
  output logic [1:0][LANE_W*LANES-1:0]      wdata_o,
  output logic [1:0][LANES-1:0]             wlane_o
);
  localparam int unsigned DATA_W = LANE_W * LANES;

  logic              pend_q;
  logic [DATA_W-1:0] d0_q;
  logic [LANES-1:0]  m0_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      d0_q   <= '0;
      m0_q   <= '0;
    end else if (k_slot_i) begin
      pend_q <= ~wr_sel_ni;
      if (!wr_sel_ni) begin
        d0_q <= wdata_i;
        m0_q <= ~bw_ni;
      end
    end
  end

  // commit both beats at the K# edge, address taken there
  assign we_o       = ~k_slot_i & pend_q;
  assign waddr_o    = addr_i;
  assign wdata_o[0] = d0_q;
  assign wdata_o[1] = wdata_i;
  assign wlane_o[0] = m0_q;
  assign wlane_o[1] = ~bw_ni;
endmodule

// File: rtl/qdr_b2_rd_path.sv
module qdr_b2_rd_path #(
  parameter int unsigned DATA_W = 36
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   k_slot_i,
  input  logic                   rd_sel_ni,
  input  logic [1:0][DATA_W-1:0] bank_d_i,
  output logic                   re_o,
  output logic [DATA_W-1:0]      rdata_o,
  output logic                   rvalid_o
);
  logic valid_q;
  logic beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      beat_q  <= 1'b0;
    end else if (k_slot_i) begin
      valid_q <= ~rd_sel_ni;
      beat_q  <= 1'b0;
    end else begin
      beat_q  <= 1'b1;
    end
  end

  assign re_o     = k_slot_i & ~rd_sel_ni;
  assign rvalid_o = valid_q;
  assign rdata_o  = valid_q ? bank_d_i[beat_q] : '0;
endmodule

// File: rtl/qdr_b2_sram.sv
module qdr_b2_sram
  import qdr_b2_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      rd_sel_ni,
  input  logic                      wr_sel_ni,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [LANE_W*LANES-1:0]   wdata_i,
  input  logic [LANES-1:0]          bw_ni,
  output logic [LANE_W*LANES-1:0]   rdata_o,
  output logic                      rvalid_o,
  output logic                      k_phase_o
);
  localparam int unsigned DATA_W = LANE_W * LANES;

  logic                          k_slot;
  logic                          wr_en;
  logic [ADDR_W-1:0]             wr_addr;
  logic [1:0][DATA_W-1:0]        wr_d;
  logic [1:0][LANES-1:0]         wr_m;
  logic                          rd_en;
  logic [1:0][DATA_W-1:0]        rd_d;

  qdr_b2_phase u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .k_slot_o (k_slot)
  );

  qdr_b2_wr_path #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_wr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .k_slot_i  (k_slot),
    .wr_sel_ni (wr_sel_ni),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .bw_ni     (bw_ni),
    .we_o      (wr_en),
    .waddr_o   (wr_addr),
    .wdata_o   (wr_d),
    .wlane_o   (wr_m)
  );

  for (genvar b = 0; b < BURST_LEN; b++) begin : g_bank
    qdr_b2_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (wr_en),
      .waddr_i (wr_addr),
      .wdata_i (wr_d[b]),
      .wlane_i (wr_m[b]),
      .re_i    (rd_en),
      .raddr_i (addr_i),
      .rdata_o (rd_d[b])
    );
  end

  qdr_b2_rd_path #(.DATA_W(DATA_W)) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .k_slot_i  (k_slot),
    .rd_sel_ni (rd_sel_ni),
    .bank_d_i  (rd_d),
    .re_o      (rd_en),
    .rdata_o   (rdata_o),
    .rvalid_o  (rvalid_o)
  );

  assign k_phase_o = k_slot;
endmodule

// File: rtl/qdr_b2_sram_chk.sv
module qdr_b2_sram_chk #(
  parameter int unsigned DATA_W = 36
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_sel_ni,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rvalid_o,
  input logic              k_phase_o
);
  p_phase_k_to_kn_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    k_phase_o |=> !k_phase_o);

  p_phase_kn_to_k_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !k_phase_o |=> k_phase_o);

  p_read_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (k_phase_o && !rd_sel_ni) |=> rvalid_o);

  p_second_beat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!k_phase_o && rvalid_o) |=> rvalid_o);

  p_deselect_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (k_phase_o && rd_sel_ni) |=> !rvalid_o);

  p_idle_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> (rdata_o == '0));
endmodule

bind qdr_b2_sram qdr_b2_sram_chk #(.DATA_W(LANE_W*LANES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_sel_ni (rd_sel_ni),
  .rdata_o   (rdata_o),
  .rvalid_o  (rvalid_o),
  .k_phase_o (k_phase_o)
);

// File: tb/qdr_b2_sram_test.sv
`timescale 1ns/1ps
module qdr_b2_sram_test;
  localparam int AW = 8;
  localparam int LW = 9;
  localparam int NL = 4;
  localparam int DW = LW * NL;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_sel_n = 1'b1;
  logic          wr_sel_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [NL-1:0] bw_n = '1;
  logic [DW-1:0] rdata;
  logic          rvalid;
  logic          k_phase;

  int compared = 0;
  int mismatched = 0;
  string cur_req = "R9";

  always #4 clk = ~clk;

  qdr_b2_sram #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .rd_sel_ni(rd_sel_n), .wr_sel_ni(wr_sel_n),
    .addr_i(addr), .wdata_i(wdata), .bw_ni(bw_n),
    .rdata_o(rdata), .rvalid_o(rvalid), .k_phase_o(k_phase)
  );

  // behavioural reference
  logic [DW-1:0] ref0 [DEPTH];
  logic [DW-1:0] ref1 [DEPTH];
  logic          exp_k = 1'b1;
  logic          exp_valid = 1'b0;
  logic [DW-1:0] exp_data = '0;
  logic [DW-1:0] hold_b1 = '0;
  logic          wpend = 1'b0;
  logic [DW-1:0] wd0 = '0;
  logic [NL-1:0] wm0 = '1;

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_k = 1'b1; exp_valid = 1'b0; exp_data = '0; wpend = 1'b0;
    end else if (exp_k) begin
      if (!rd_sel_n) begin
        exp_valid = 1'b1; exp_data = ref0[addr]; hold_b1 = ref1[addr];
      end else begin
        exp_valid = 1'b0; exp_data = '0;
      end
      wpend = !wr_sel_n;
      if (wpend) begin wd0 = wdata; wm0 = bw_n; end
      exp_k = 1'b0;
    end else begin
      if (exp_valid) exp_data = hold_b1;
      if (wpend) begin
        for (int l = 0; l < NL; l++) begin
          if (!wm0[l])  ref0[addr][l*LW +: LW] = wd0[l*LW +: LW];
          if (!bw_n[l]) ref1[addr][l*LW +: LW] = wdata[l*LW +: LW];
        end
      end
      wpend = 1'b0;
      exp_k = 1'b1;
    end
  end

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("R1", DW'(k_phase), DW'(exp_k));
      check("R3 R7 valid", DW'(rvalid), DW'(exp_valid));
      check(cur_req, rdata, exp_data);
    end
  end

  // one K cycle: first half feeds the K edge, second half the K# edge
  task automatic kcyc(input logic rn, input logic wn, input logic [AW-1:0] ra,
                      input logic [AW-1:0] wa, input logic [DW-1:0] d0,
                      input logic [NL-1:0] m0, input logic [DW-1:0] d1,
                      input logic [NL-1:0] m1);
    rd_sel_n = rn; wr_sel_n = wn; addr = ra; wdata = d0; bw_n = m0;
    @(negedge clk);
    rd_sel_n = ~rn; wr_sel_n = ~wn; addr = wa; wdata = d1; bw_n = m1;
    @(negedge clk);
  endtask

  function automatic logic [DW-1:0] rnd();
    return {$urandom(), $urandom()};
  endfunction

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 during reset
    check("R9 rvalid", DW'(rvalid), '0);
    check("R9 rdata", rdata, '0);
    check("R9 kphase", DW'(k_phase), DW'(1'b1));
    rst_n = 1'b1;
    #1;
    check("R9 rvalid", DW'(rvalid), '0);

    // R6: fill every pair with distinct beats, reading back the previous one
    cur_req = "R6";
    for (int i = 0; i < DEPTH; i++)
      kcyc(i == 0, 1'b0, AW'(i - 1), AW'(i), {NL{LW'(i)}}, '0, ~{NL{LW'(i + 3)}}, '0);

    // R5: partial lane masks, then read back
    cur_req = "R5";
    for (int i = 0; i < 64; i++) begin
      logic [AW-1:0] a;
      a = AW'($urandom());
      kcyc(1'b1, 1'b0, AW'($urandom()), a, rnd(), NL'($urandom()), rnd(), NL'($urandom()));
      kcyc(1'b0, 1'b1, a, AW'($urandom()), rnd(), NL'($urandom()), rnd(), NL'($urandom()));
    end
    // single-lane walk
    for (int l = 0; l < NL; l++) begin
      logic [NL-1:0] m;
      m = ~(NL'(1) << l);
      kcyc(1'b1, 1'b0, 8'h00, 8'h10, '1, m, '1, m);
      kcyc(1'b0, 1'b1, 8'h10, 8'h00, '0, '0, '0, '0);
    end

    // R2: deselected write with garbage, then read
    cur_req = "R2";
    for (int i = 0; i < 16; i++) begin
      kcyc(1'b1, 1'b1, AW'(i), AW'(i), rnd(), '0, rnd(), '0);
      kcyc(1'b0, 1'b1, AW'(i), AW'(i), '0, '0, '0, '0);
    end

    // R4: read address only at K, write address only at K#
    cur_req = "R4";
    for (int i = 0; i < 32; i++)
      kcyc(1'b0, 1'b0, AW'($urandom()), AW'($urandom()), rnd(), '0, rnd(), '0);

    // R8: same address read and write started together
    cur_req = "R8";
    for (int i = 0; i < 16; i++) begin
      logic [AW-1:0] a;
      a = AW'($urandom());
      kcyc(1'b0, 1'b0, a, a, rnd(), NL'($urandom()), rnd(), NL'($urandom()));
      kcyc(1'b0, 1'b1, a, a, '0, '0, '0, '0);
    end

    // R7: back-to-back bursts then deselect
    cur_req = "R7";
    for (int n = 0; n < 4; n++) begin
      for (int i = 0; i < n + 1; i++) kcyc(1'b0, 1'b1, AW'($urandom()), '0, '0, '0, '0, '0);
      kcyc(1'b1, 1'b1, AW'($urandom()), '0, rnd(), '0, '0, '0);
      kcyc(1'b1, 1'b1, '0, '0, '0, '0, '0, '0);
    end

    // R3: random mix
    cur_req = "R3";
    for (int i = 0; i < 400; i++)
      kcyc(1'($urandom()), 1'($urandom()), AW'($urandom()), AW'($urandom()),
           rnd(), NL'($urandom()), rnd(), NL'($urandom()));

    kcyc(1'b1, 1'b1, '0, '0, '0, '1, '0, '1);
    finish_run();
  end
endmodule